// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Waveform Generator

This block is a 16-bit counter that steps on a prescaler tick and shapes one pulse-width-modulated output. A 4-bit mode input selects one of sixteen behaviours:

- plain free counting;
- clear-on-compare;
- single-slope (fast) PWM;
- dual-slope phase-correct PWM;
- phase-and-frequency-correct PWM;
- one reserved code.

The ceiling of the count, called TOP, is either a fixed value or the content of one of two registers: the compare-A register or the capture register. The chosen mode also fixes when compare writes reach the comparators and when the overflow flag is raised.

Compare registers A and B are double-buffered. Register B drives the output pin. Register A can serve as TOP. Two sticky flags report overflow and compare-B match, and each has a clear strobe. The prescaler and the bus decode sit outside the block. Software-side logic drives the write strobes directly.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset the counter is 0, the pin is 0, both flags are 0, all compare and capture registers are 0, and the count direction is up.
- R2: The counter, the pin, the flags and the compare loads change only on clock edges where `tick` is 1; with `tick` at 0 the counter holds its value.
- R3: TOP by mode code: 0 gives 0xFFFF; 1 and 5 give 0x00FF; 2 and 6 give 0x01FF; 3 and 7 give 0x03FF; 4, 9, 11 and 15 use the active compare-A value; 8, 10, 12 and 14 use the capture register.
- R4: Single-slope modes (0, 4, 5, 6, 7, 12, 14, 15) count up and step to 0 on the tick taken while the counter equals TOP. After N ticks from 0 the count is N mod (TOP+1).
- R5: Dual-slope modes (1, 2, 3, 8, 9, 10, 11) count up to TOP and then down to 0. The tick taken at TOP gives TOP-1, and the tick taken at 0 while descending gives 1. After N ticks from reset the count is p when p = N mod 2·TOP is at most TOP, and 2·TOP−p otherwise.
- R6: The overflow flag is set as follows:
  - modes 0, 4 and 12: on a tick with the counter at 0xFFFF;
  - modes 5, 6, 7, 14 and 15: on a tick with the counter at TOP;
  - modes 1, 2, 3, 8, 9, 10 and 11: on a tick with the counter at 0.

  A pulse on `ovf_clr` clears it, and a set in the same cycle wins.
- R7: In modes 0, 4 and 12 a compare write is active from the next cycle. In modes 1, 2, 3, 10 and 11 the buffered value becomes active on the tick taken at TOP. In modes 5 to 9, 14 and 15 it becomes active on the tick taken at 0. The capture register is always written directly.
- R8: The match flag is set on a tick with the counter equal to the active compare-B value. A pulse on `match_clr` clears it, and a set wins.
- R9: In modes 5, 6, 7, 14 and 15 the pin goes to 0 on a tick at compare-B match; otherwise it goes to 1 on a tick with the counter at 0.
- R10: In the dual-slope modes the pin goes to 0 on a tick at match while counting up, and to 1 on a tick at match while counting down.
- R11: In modes 0, 4 and 12 the pin toggles on every tick at compare-B match.
- R12: Mode 13 is reserved. In it the counter, the pin and the flags keep their values on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler step enable |
| mode | input | 4 | Waveform mode code |
| cmpa_we | input | 1 | Compare-A write strobe |
| cmpa_wdata | input | 16 | Compare-A write data |
| cmpb_we | input | 1 | Compare-B write strobe |
| cmpb_wdata | input | 16 | Compare-B write data |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register write data |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| match_clr | input | 1 | Match flag clear pulse |
| cnt | output | 16 | Counter value |
| pwm_out | output | 1 | Waveform pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-B match flag |

## Verification
A buffer load and a compare can happen on the same tick, so the bench makes that happen on purpose. In single-slope PWM it writes a new compare-B value halfway through a period. It then checks that the old value still drives the match up to the wrap. On the tick taken at 0, the new value is loaded while the comparator still sees the old one. The flag and pin are then judged exactly at the new match count and one tick before it. A dual-slope case does the same at TOP and checks the pin edges on the downward and upward slopes.

// File: rtl/tmr_wg_pkg.sv
package tmr_wg_pkg;

  // point in the count at which an action happens
  typedef enum logic [1:0] {
    PT_IMM = 2'd0,
    PT_TOP = 2'd1,
    PT_BOT = 2'd2,
    PT_MAX = 2'd3
  } point_e;

  // where the ceiling of the count comes from
  typedef enum logic [2:0] {
    TS_FULL = 3'd0,
    TS_B8   = 3'd1,
    TS_B9   = 3'd2,
    TS_B10  = 3'd3,
    TS_CMPA = 3'd4,
    TS_CAP  = 3'd5
  } topsrc_e;

  typedef struct packed {
    topsrc_e tsrc;
    logic    dual;
    logic    pwm;
    logic    frozen;
    point_e  upd;
    point_e  ovf;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c.tsrc   = TS_FULL;
    c.dual   = 1'b0;
    c.pwm    = 1'b0;
    c.frozen = 1'b0;
    c.upd    = PT_IMM;
    c.ovf    = PT_MAX;
    case (m)
      4'd1, 4'd2, 4'd3: begin
        c.tsrc = (m == 4'd1) ? TS_B8 : (m == 4'd2) ? TS_B9 : TS_B10;
        c.dual = 1'b1; c.pwm = 1'b1; c.upd = PT_TOP; c.ovf = PT_BOT;
      end
      4'd4:  c.tsrc = TS_CMPA;
      4'd5, 4'd6, 4'd7: begin
        c.tsrc = (m == 4'd5) ? TS_B8 : (m == 4'd6) ? TS_B9 : TS_B10;
        c.pwm = 1'b1; c.upd = PT_BOT; c.ovf = PT_TOP;
      end
      4'd8, 4'd9: begin
        c.tsrc = (m == 4'd8) ? TS_CAP : TS_CMPA;
        c.dual = 1'b1; c.pwm = 1'b1; c.upd = PT_BOT; c.ovf = PT_BOT;
      end
      4'd10, 4'd11: begin
        c.tsrc = (m == 4'd10) ? TS_CAP : TS_CMPA;
        c.dual = 1'b1; c.pwm = 1'b1; c.upd = PT_TOP; c.ovf = PT_BOT;
      end
      4'd12: c.tsrc = TS_CAP;
      4'd13: c.frozen = 1'b1;
      4'd14, 4'd15: begin
        c.tsrc = (m == 4'd14) ? TS_CAP : TS_CMPA;
        c.pwm = 1'b1; c.upd = PT_BOT; c.ovf = PT_TOP;
      end
      default: ;
    endcase
    return c;
  endfunction

  // event at a chosen point, given the three position comparisons
  function automatic logic point_hit(input point_e p, input logic at_top,
                                     input logic at_bot, input logic at_max);
    case (p)
      PT_TOP:  return at_top;
      PT_BOT:  return at_bot;
      PT_MAX:  return at_max;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_wg_cmpbuf.sv
module tmr_wg_cmpbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         imm,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (we) hold_q <= wdata;
      if (imm && we)  act_q <= wdata;
      else if (load)  act_q <= hold_q;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/tmr_wg_counter.sv
module tmr_wg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         dual,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;

  // single slope: wrap after the ceiling
  function automatic logic [W-1:0] single_next(input logic [W-1:0] c,
                                                input logic [W-1:0] t);
    return (c == t) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (!dual) begin
      down_d = 1'b0;
      cnt_d  = single_next(cnt_q, top);
    end else if (!down_q) begin
      if (cnt_q >= top) begin
        down_d = 1'b1;
        cnt_d  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        down_d = 1'b0;
        cnt_d  = (top == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
      end else begin
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt  = cnt_q;
  assign down = down_q;
endmodule

// File: rtl/tmr_wg_outgen.sv
module tmr_wg_outgen (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic pwm_en,
  input  logic dual,
  input  logic down,
  input  logic eq_cmp,
  input  logic at_bot,
  input  logic ovf_hit,
  input  logic ovf_clr,
  input  logic match_clr,
  output logic pwm,
  output logic ovf_flag,
  output logic match_flag
);
  logic pwm_q, ovf_q, mat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      ovf_q <= 1'b0;
      mat_q <= 1'b0;
    end else begin
      if (step && ovf_hit)     ovf_q <= 1'b1;
      else if (ovf_clr)        ovf_q <= 1'b0;
      if (step && eq_cmp)      mat_q <= 1'b1;
      else if (match_clr)      mat_q <= 1'b0;
      if (step) begin
        if (!pwm_en) begin
          if (eq_cmp) pwm_q <= ~pwm_q;
        end else if (dual) begin
          if (eq_cmp) pwm_q <= down;
        end else begin
          if (eq_cmp)      pwm_q <= 1'b0;
          else if (at_bot) pwm_q <= 1'b1;
        end
      end
    end
  end

  assign pwm        = pwm_q;
  assign ovf_flag   = ovf_q;
  assign match_flag = mat_q;
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic         cmpa_we,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cmpb_we,
  input  logic [W-1:0] cmpb_wdata,
  input  logic         cap_we,
  input  logic [W-1:0] cap_wdata,
  input  logic         ovf_clr,
  input  logic         match_clr,
  output logic [W-1:0] cnt,
  output logic         pwm_out,
  output logic         ovf_flag,
  output logic         match_flag
);
  import tmr_wg_pkg::*;

  localparam int NCH = 2;
  localparam logic [W-1:0] TOP_B8   = W'((1 << 8)  - 1);
  localparam logic [W-1:0] TOP_B9   = W'((1 << 9)  - 1);
  localparam logic [W-1:0] TOP_B10  = W'((1 << 10) - 1);
  localparam logic [W-1:0] TOP_FULL = '1;

  mode_cfg_t    cfg;
  logic [W-1:0] top_val, cap_q, cnt_w;
  logic         down_w;
  logic         step, at_top, at_bot, at_max, eq_cmp, ovf_hit, upd_hit, imm;
  logic [NCH-1:0]        ch_we;
  logic [NCH-1:0][W-1:0] ch_wd;
  logic [NCH-1:0][W-1:0] ch_act;

  assign cfg    = decode_mode(mode);
  assign step   = tick && !cfg.frozen;
  assign at_top = (cnt_w == top_val);
  assign at_bot = (cnt_w == '0);
  assign at_max = (cnt_w == TOP_FULL);
  assign eq_cmp = (cnt_w == ch_act[1]);
  assign imm    = (cfg.upd == PT_IMM);
  assign ovf_hit = point_hit(cfg.ovf, at_top, at_bot, at_max);
  assign upd_hit = step && point_hit(cfg.upd, at_top, at_bot, 1'b0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_we) cap_q <= cap_wdata;
  end

  always_comb begin
    case (cfg.tsrc)
      TS_B8:   top_val = TOP_B8;
      TS_B9:   top_val = TOP_B9;
      TS_B10:  top_val = TOP_B10;
      TS_CMPA: top_val = ch_act[0];
      TS_CAP:  top_val = cap_q;
      default: top_val = TOP_FULL;
    endcase
  end

  assign ch_we = {cmpb_we, cmpa_we};
  assign ch_wd = {cmpb_wdata, cmpa_wdata};

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    tmr_wg_cmpbuf #(.W(W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ch_we[g]),
      .wdata  (ch_wd[g]),
      .imm    (imm),
      .load   (upd_hit),
      .active (ch_act[g])
    );
  end

  tmr_wg_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .dual  (cfg.dual),
    .top   (top_val),
    .cnt   (cnt_w),
    .down  (down_w)
  );

  tmr_wg_outgen u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .pwm_en     (cfg.pwm),
    .dual       (cfg.dual),
    .down       (down_w),
    .eq_cmp     (eq_cmp),
    .at_bot     (at_bot),
    .ovf_hit    (ovf_hit),
    .ovf_clr    (ovf_clr),
    .match_clr  (match_clr),
    .pwm        (pwm_out),
    .ovf_flag   (ovf_flag),
    .match_flag (match_flag)
  );

  assign cnt = cnt_w;
endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [3:0]   mode,
  input logic         cmpb_we,
  input logic [W-1:0] cmpb_wdata,
  input logic [W-1:0] cnt,
  input logic         at_top,
  input logic         imm,
  input logic         dual_mode,
  input logic [W-1:0] cmpb_active,
  input logic         ovf_flag,
  input logic         match_flag,
  input logic         pwm_out
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2

  AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dual_mode && at_top && mode != 4'd13) |=> (cnt == '0)); // R4

  AST_OVF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tick)); // R6

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (imm && cmpb_we) |=> (cmpb_active == $past(cmpb_wdata))); // R7

  AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(tick)); // R8

  AST_RSV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13) |=> ($stable(cnt) && $stable(pwm_out))); // R12
endmodule

bind tmr_wavegen tmr_wavegen_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .mode        (mode),
  .cmpb_we     (cmpb_we),
  .cmpb_wdata  (cmpb_wdata),
  .cnt         (cnt_w),
  .at_top      (at_top),
  .imm         (imm),
  .dual_mode   (cfg.dual),
  .cmpb_active (ch_act[1]),
  .ovf_flag    (ovf_flag),
  .match_flag  (match_flag),
  .pwm_out     (pwm_out)
);

// File: tb/sim_tmr_wavegen.sv
`timescale 1ns/1ps
module sim_tmr_wavegen;
  logic        clk = 1'b0;
  logic        rst_n, tick, cmpa_we, cmpb_we, cap_we, ovf_clr, match_clr;
  logic [3:0]  mode;
  logic [15:0] cmpa_wdata, cmpb_wdata, cap_wdata, cnt;
  logic        pwm_out, ovf_flag, match_flag;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_wavegen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
    .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
    .cap_we(cap_we), .cap_wdata(cap_wdata),
    .ovf_clr(ovf_clr), .match_clr(match_clr),
    .cnt(cnt), .pwm_out(pwm_out), .ovf_flag(ovf_flag), .match_flag(match_flag)
  );

  typedef struct packed {
    logic [3:0]  md;
    logic [15:0] topv;
    logic [15:0] nt;
    logic [15:0] exp;
  } vec_t;

  // mode, ceiling value, ticks, expected count (R4 single slope / R5 dual slope)
  localparam vec_t VECS [12] = '{
    '{4'd0,  16'd0,  16'd300,  16'd300},
    '{4'd5,  16'd0,  16'd300,  16'd44},
    '{4'd6,  16'd0,  16'd600,  16'd88},
    '{4'd7,  16'd0,  16'd1030, 16'd6},
    '{4'd1,  16'd0,  16'd300,  16'd210},
    '{4'd2,  16'd0,  16'd1100, 16'd78},
    '{4'd3,  16'd0,  16'd2100, 16'd54},
    '{4'd12, 16'd99, 16'd250,  16'd50},
    '{4'd14, 16'd49, 16'd120,  16'd20},
    '{4'd10, 16'd40, 16'd130,  16'd30},
    '{4'd8,  16'd60, 16'd100,  16'd20},
    '{4'd4,  16'd30, 16'd75,   16'd13}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; mode = m;
    cmpa_we = 1'b0; cmpb_we = 1'b0; cap_we = 1'b0;
    ovf_clr = 1'b0; match_clr = 1'b0;
    cmpa_wdata = '0; cmpb_wdata = '0; cap_wdata = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int which, input logic [15:0] v);
    @(negedge clk);
    case (which)
      0: begin cmpa_we = 1'b1; cmpa_wdata = v; end
      1: begin cmpb_we = 1'b1; cmpb_wdata = v; end
      default: begin cap_we = 1'b1; cap_wdata = v; end
    endcase
    @(negedge clk);
    cmpa_we = 1'b0; cmpb_we = 1'b0; cap_we = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic pulse_match_clr();
    @(negedge clk); match_clr = 1'b1;
    @(negedge clk); match_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(4'd0);
    @(negedge clk);
    check("R1 cnt", cnt, 16'd0);
    check("R1 pwm", {15'd0, pwm_out}, 16'd0);
    check("R1 ovf", {15'd0, ovf_flag}, 16'd0);
    check("R1 match", {15'd0, match_flag}, 16'd0);

    // table walk: R3 ceilings with R4 and R5 count shapes
    foreach (VECS[i]) begin
      do_reset(VECS[i].md);
      wr(2, VECS[i].topv);
      wr(0, VECS[i].topv);
      run(int'(VECS[i].nt));
      @(negedge clk);
      check($sformatf("R3 R4 R5 vector %0d mode %0d", i, VECS[i].md), cnt, VECS[i].exp);
    end

    // R2: no tick, no movement
    repeat (5) @(negedge clk);
    check("R2 hold", cnt, 16'd13);
    // R6 CTC on compare A never reaches 0xFFFF, so no overflow
    check("R6 ctc no ovf", {15'd0, ovf_flag}, 16'd0);

    // R7 compare A as ceiling in mode 15 loads on the first bottom tick
    do_reset(4'd15);
    wr(0, 16'd9);
    run(25);
    check("R7 cmpa buffered ceiling", cnt, 16'd4);

    // R6 normal mode: overflow at 0xFFFF, then clear
    do_reset(4'd0);
    run(65535);
    check("R6 normal cnt max", cnt, 16'hFFFF);
    check("R6 normal before max", {15'd0, ovf_flag}, 16'd0);
    run(1);
    check("R6 normal at max", {15'd0, ovf_flag}, 16'd1);
    check("R4 normal wrap", cnt, 16'd0);
    pulse_ovf_clr();
    check("R6 clear", {15'd0, ovf_flag}, 16'd0);

    // R6 fast 8-bit: overflow at ceiling
    do_reset(4'd5);
    run(255);
    check("R6 fast before top", {15'd0, ovf_flag}, 16'd0);
    run(1);
    check("R6 fast at top", {15'd0, ovf_flag}, 16'd1);

    // R6 dual 8-bit: overflow at bottom only
    do_reset(4'd1);
    run(1);
    check("R6 dual first bottom", {15'd0, ovf_flag}, 16'd1);
    pulse_ovf_clr();
    run(509);
    check("R5 dual back at zero", cnt, 16'd0);
    check("R6 dual no set at top", {15'd0, ovf_flag}, 16'd0);
    run(1);
    check("R6 dual at bottom", {15'd0, ovf_flag}, 16'd1);
    check("R5 dual turn", cnt, 16'd1);

    // R11 normal mode toggle with immediate compare B (R7 immediate)
    do_reset(4'd0);
    wr(1, 16'd10);
    run(10);
    check("R8 no match yet", {15'd0, match_flag}, 16'd0);
    check("R11 pin before", {15'd0, pwm_out}, 16'd0);
    run(1);
    check("R8 match set", {15'd0, match_flag}, 16'd1);
    check("R11 pin toggled", {15'd0, pwm_out}, 16'd1);

    // R9 with R7 buffering in fast PWM on the capture ceiling
    do_reset(4'd14);
    wr(2, 16'd99);
    wr(1, 16'd20);
    run(50);
    check("R9 pin low after match", {15'd0, pwm_out}, 16'd0);
    pulse_match_clr();
    check("R8 match cleared", {15'd0, match_flag}, 16'd0);
    wr(1, 16'd70);
    run(30);
    check("R7 buffered write not active", {15'd0, match_flag}, 16'd0);
    run(20);
    check("R4 wrap to zero", cnt, 16'd0);
    run(70);
    check("R9 pin set at bottom", {15'd0, pwm_out}, 16'd1);
    check("R7 old value gone", {15'd0, match_flag}, 16'd0);
    run(1);
    check("R7 new compare active", {15'd0, match_flag}, 16'd1);
    check("R9 pin clear at match", {15'd0, pwm_out}, 16'd0);

    // R10 dual slope pin, compare loaded at the ceiling (mode 10)
    do_reset(4'd10);
    wr(2, 16'd40);
    wr(1, 16'd10);
    run(70);
    check("R10 pin low on descent", {15'd0, pwm_out}, 16'd0);
    run(1);
    check("R10 pin set at down match", {15'd0, pwm_out}, 16'd1);
    run(19);
    check("R10 pin held", {15'd0, pwm_out}, 16'd1);
    run(1);
    check("R10 pin clear at up match", {15'd0, pwm_out}, 16'd0);

    // R12 reserved mode freezes the count and the flags
    do_reset(4'd13);
    run(10);
    check("R12 cnt frozen", cnt, 16'd0);
    check("R12 ovf untouched", {15'd0, ovf_flag}, 16'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule